// File: doc/BRIEF.md
# Interrupt and Bus-Request Arbiter

This block decides what a small 8-bit processor core does next when outside agents want its attention. It watches an external bus request, a non-maskable interrupt and three maskable interrupt lines, all active low and asynchronous. The core's sequencer tells it when a machine cycle ends and when an instruction ends. The block either hands the external bus to another master, or starts an interrupt acknowledge cycle of the right kind. It also holds the core in its halt/sleep wait state and keeps the bus drivers off while reset is asserted.

Bus requests are served at the end of any machine cycle. Interrupts are served only at instruction boundaries, in a fixed priority order. Every asynchronous request passes through a synchronizer chain before it takes part in arbitration. The block does not drive the address or data buses itself. It produces output-enable signals for the address, data and control-strobe drivers, an active-low bus acknowledge, the M1 and IORQ strobes for the acknowledge cycle, and a code naming the source being acknowledged.

Top module: `intBusArbiter`

## Requirements
- R1: An active bus request is granted at the next cycle-end or instruction-end strobe, even in the middle of an instruction. It wins over a pending non-maskable interrupt and over every maskable interrupt at the same strobe.
- R2: On a grant, `addrOe`, `dataOe` and `ctrlOe` go low at least one clock before `busAckN` goes low. `busAckN` stays high whenever any enable is high. After the request is removed, `busAckN` returns high and the enables return high.
- R3: Interrupt 0 is accepted at an instruction-end strobe only when no bus request is active and no non-maskable interrupt is pending.
- R4: Interrupts 1 and 2 are accepted only when the bus request, the pending non-maskable interrupt and interrupt 0 are all absent. Interrupt 1 wins over interrupt 2.
- R5: The acknowledge of interrupt 0 drives `m1N` and `iorqN` low for exactly ACK_CYCLES clocks. During it, `ackActive` is 1 and `ackKind` is 1.
- R6: The acknowledges of the non-maskable interrupt (`ackKind` 0), interrupt 1 (`ackKind` 2) and interrupt 2 (`ackKind` 3) keep `m1N` and `iorqN` high. Each lasts ACK_CYCLES clocks.
- R7: An instruction-end strobe with `haltInstr` set drives `haltN` low. It stays low until a pending non-maskable interrupt or an enabled maskable interrupt arrives. That interrupt is then acknowledged and `haltN` returns high.
- R8: While `rstN` is low, all three enables are low, and `busAckN`, `haltN`, `m1N` and `iorqN` are high, with `ackActive` low.
- R9: The non-maskable interrupt is latched on the falling edge of `nmiN` and cleared when its acknowledge starts. If the line is held low, it is not acknowledged a second time.
- R10: Maskable interrupt i is accepted only while `intEnable` is 1 and bit i of `intMask` is 1. A request that is disabled by either one is not acknowledged, and it does not end a halt.
- R11: A bus grant during halt keeps `haltN` low for the whole grant. After the request is removed, the block goes back to halt with `haltN` still low.
- R12: A cycle-end strobe that is not also an instruction end never starts an interrupt acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReqN | input | 1 | External bus request, active low, asynchronous |
| nmiN | input | 1 | Non-maskable interrupt, falling-edge triggered, asynchronous |
| intN | input | 3 | Maskable interrupt lines 0..2, active low, level sensitive |
| cycleEnd | input | 1 | Strobe from the sequencer: last clock of a machine cycle |
| instrEnd | input | 1 | Strobe from the sequencer: last clock of an instruction |
| haltInstr | input | 1 | Qualifies `instrEnd`: the instruction just finished was HALT or SLP |
| intEnable | input | 1 | Global maskable-interrupt enable |
| intMask | input | 3 | Per-source enables for maskable interrupts 0..2 |
| addrOe | output | 1 | Address-bus driver enable (0 = high impedance) |
| dataOe | output | 1 | Data-bus driver enable (0 = high impedance) |
| ctrlOe | output | 1 | Control-strobe driver enable (0 = high impedance) |
| busAckN | output | 1 | Bus acknowledge, active low |
| m1N | output | 1 | M1 strobe for the acknowledge cycle, active low |
| iorqN | output | 1 | IORQ strobe for the acknowledge cycle, active low |
| haltN | output | 1 | Halt/sleep indication, active low |
| ackActive | output | 1 | An interrupt acknowledge cycle is in progress |
| ackKind | output | 2 | Source being acknowledged: 0 NMI, 1 INT0, 2 INT1, 3 INT2 |

## Verification
The bench builds the block with SYNC_STAGES = 3 and ACK_CYCLES = 5. The extra synchronizer stage tests that every wait derived from the chain depth is really counted from the parameter, not from a fixed two-stage delay. The five-clock acknowledge makes a cycle miscount in the acknowledge counter show up as a wrong length for every source. The directed cases cover grants during halt, a non-maskable interrupt held low across two boundaries, and requests that arrive at a cycle end but not at an instruction end. Random trials then mix all the requests and enables against a priority function kept in the bench.

// File: rtl/arbPkg.sv
package arbPkg;

  localparam int NUM_IRQ = 3;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_RELEASE,
    ST_GRANT,
    ST_ACK,
    ST_HALT
  } arbState_t;

  // Encoding is visible on the ackKind port.
  typedef enum logic [1:0] {
    K_NMI  = 2'd0,
    K_INT0 = 2'd1,
    K_INT1 = 2'd2,
    K_INT2 = 2'd3
  } ackKind_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic     busFloat;
    logic     busAck;
    logic     ackOn;
    logic     ackIorq;
    logic     haltOn;
    logic     clrNmi;
    ackKind_t kind;
  } arbStrobe_t;

endpackage

// File: rtl/arbSync.sv
module arbSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
#(
  parameter int ACK_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReq,
  input  logic               nmiPend,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               intEnable,
  input  logic [NUM_IRQ-1:0] intMask,
  input  logic               cycleEnd,
  input  logic               instrEnd,
  input  logic               haltInstr,
  output arbStrobe_t         strobe
);

  localparam int CW = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
  localparam logic [CW-1:0] ACK_LAST = CW'(ACK_CYCLES - 1);

  arbState_t          state, stateNext;
  ackKind_t           kindReg, kindNext, pickKind;
  logic [CW-1:0]      ackCnt, ackCntNext;
  logic               resumeHalt, resumeHaltNext;
  logic [NUM_IRQ-1:0] irqOk;
  logic               wantInt;

  assign irqOk   = irq & intMask & {NUM_IRQ{intEnable}};
  assign wantInt = nmiPend | (|irqOk);

  // Fixed priority among interrupt sources.
  always_comb begin
    if (nmiPend)       pickKind = K_NMI;
    else if (irqOk[0]) pickKind = K_INT0;
    else if (irqOk[1]) pickKind = K_INT1;
    else               pickKind = K_INT2;
  end

  always_comb begin
    stateNext      = state;
    kindNext       = kindReg;
    ackCntNext     = ackCnt;
    resumeHaltNext = resumeHalt;
    unique case (state)
      ST_RUN: begin
        if (busReq && (cycleEnd || instrEnd)) begin
          stateNext      = ST_RELEASE;
          resumeHaltNext = 1'b0;
        end else if (instrEnd && wantInt) begin
          stateNext  = ST_ACK;
          kindNext   = pickKind;
          ackCntNext = '0;
        end else if (instrEnd && haltInstr) begin
          stateNext = ST_HALT;
        end
      end
      ST_HALT: begin
        if (busReq) begin
          stateNext      = ST_RELEASE;
          resumeHaltNext = 1'b1;
        end else if (wantInt) begin
          stateNext  = ST_ACK;
          kindNext   = pickKind;
          ackCntNext = '0;
        end
      end
      ST_RELEASE: stateNext = ST_GRANT;
      ST_GRANT: begin
        if (!busReq) stateNext = resumeHalt ? ST_HALT : ST_RUN;
      end
      ST_ACK: begin
        if (ackCnt == ACK_LAST) stateNext = ST_RUN;
        else                    ackCntNext = ackCnt + 1'b1;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      kindReg    <= K_NMI;
      ackCnt     <= '0;
      resumeHalt <= 1'b0;
    end else begin
      state      <= stateNext;
      kindReg    <= kindNext;
      ackCnt     <= ackCntNext;
      resumeHalt <= resumeHaltNext;
    end
  end

  always_comb begin
    strobe.busFloat = (state == ST_RELEASE) || (state == ST_GRANT);
    strobe.busAck   = (state == ST_GRANT);
    strobe.ackOn    = (state == ST_ACK);
    strobe.ackIorq  = (state == ST_ACK) && (kindReg == K_INT0);
    strobe.haltOn   = (state == ST_HALT) ||
                      (((state == ST_RELEASE) || (state == ST_GRANT)) && resumeHalt);
    strobe.clrNmi   = (stateNext == ST_ACK) && (state != ST_ACK) && (pickKind == K_NMI);
    strobe.kind     = kindReg;
  end

  // Bus request taken at a cycle end.
  assert_busAtCycleEnd_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && busReq && (cycleEnd || instrEnd)) |=> (state == ST_RELEASE));

  // Interrupt 0 only with bus and NMI quiet.
  assert_int0Quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && $past(state) != ST_ACK && kindReg == K_INT0)
      |-> ($past(!busReq) && $past(!nmiPend)));

  // Interrupt 2 only when interrupts 0 and 1 are not eligible.
  assert_int2Last_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && $past(state) != ST_ACK && kindReg == K_INT2)
      |-> $past(!irqOk[0] && !irqOk[1] && !nmiPend && !busReq));

  // Halt holds with nothing to wake it.
  assert_haltHold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !busReq && !wantInt) |=> (state == ST_HALT));

  // Grant taken from halt goes back to halt.
  assert_grantBackToHalt_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRANT && resumeHalt && !busReq) |=> (state == ST_HALT));

  // No interrupt acknowledge without an instruction end while running.
  assert_noMidInstrAck_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !instrEnd) |=> (state != ST_ACK));

endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiLvl,
  input  arbStrobe_t strobe,
  output logic       nmiPend,
  output logic       addrOe,
  output logic       dataOe,
  output logic       ctrlOe,
  output logic       busAckN,
  output logic       m1N,
  output logic       iorqN,
  output logic       haltN,
  output logic       ackActive,
  output logic [1:0] ackKind
);

  logic nmiPrev;

  // Edge latch for the non-maskable request; a new edge wins over the clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiLvl;
      nmiPend <= (nmiLvl & ~nmiPrev) | (nmiPend & ~strobe.clrNmi);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOe    <= 1'b0;
      dataOe    <= 1'b0;
      ctrlOe    <= 1'b0;
      busAckN   <= 1'b1;
      m1N       <= 1'b1;
      iorqN     <= 1'b1;
      haltN     <= 1'b1;
      ackActive <= 1'b0;
      ackKind   <= 2'd0;
    end else begin
      addrOe    <= ~strobe.busFloat;
      dataOe    <= ~strobe.busFloat;
      ctrlOe    <= ~strobe.busFloat;
      busAckN   <= ~strobe.busAck;
      m1N       <= ~strobe.ackIorq;
      iorqN     <= ~strobe.ackIorq;
      haltN     <= ~strobe.haltOn;
      ackActive <= strobe.ackOn;
      ackKind   <= strobe.kind;
    end
  end

  // Bus acknowledge only with all drivers off.
  assert_ackWithFloat_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busAckN |-> (!addrOe && !dataOe && !ctrlOe));

  // Drivers released at least one clock before the acknowledge.
  assert_floatFirst_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckN) |-> $past(!addrOe));

  // M1/IORQ only during an interrupt 0 acknowledge.
  assert_iorqOnlyInt0_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN || !m1N) |-> (ackActive && ackKind == K_INT0));

  // Other acknowledges keep both strobes high.
  assert_quietOtherAck_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackActive && ackKind != K_INT0) |-> (m1N && iorqN));

  // A fresh edge is always latched.
  assert_nmiEdgeLatched_R9: assert property (@(posedge clk) disable iff (!rstN)
    (nmiLvl && !nmiPrev) |=> nmiPend);

endmodule

// File: rtl/intBusArbiter.sv
module intBusArbiter
  import arbPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYCLES  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReqN,
  input  logic       nmiN,
  input  logic [2:0] intN,
  input  logic       cycleEnd,
  input  logic       instrEnd,
  input  logic       haltInstr,
  input  logic       intEnable,
  input  logic [2:0] intMask,
  output logic       addrOe,
  output logic       dataOe,
  output logic       ctrlOe,
  output logic       busAckN,
  output logic       m1N,
  output logic       iorqN,
  output logic       haltN,
  output logic       ackActive,
  output logic [1:0] ackKind
);

  localparam int SYNC_W = NUM_IRQ + 2;

  logic [SYNC_W-1:0]  syncIn, syncOut;
  logic               busReq, nmiLvl, nmiPend;
  logic [NUM_IRQ-1:0] irq;
  arbStrobe_t         strobe;

  assign syncIn = {~intN, ~nmiN, ~busReqN};
  assign busReq = syncOut[0];
  assign nmiLvl = syncOut[1];
  assign irq    = syncOut[SYNC_W-1:2];

  arbSync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (syncIn),
    .dout(syncOut)
  );

  arbCtrl #(.ACK_CYCLES(ACK_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .nmiPend  (nmiPend),
    .irq      (irq),
    .intEnable(intEnable),
    .intMask  (intMask),
    .cycleEnd (cycleEnd),
    .instrEnd (instrEnd),
    .haltInstr(haltInstr),
    .strobe   (strobe)
  );

  arbDatapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .nmiLvl   (nmiLvl),
    .strobe   (strobe),
    .nmiPend  (nmiPend),
    .addrOe   (addrOe),
    .dataOe   (dataOe),
    .ctrlOe   (ctrlOe),
    .busAckN  (busAckN),
    .m1N      (m1N),
    .iorqN    (iorqN),
    .haltN    (haltN),
    .ackActive(ackActive),
    .ackKind  (ackKind)
  );

endmodule

// File: tb/sim_intBusArbiter.sv
module sim_intBusArbiter;

  localparam int SYNC   = 3;
  localparam int ACKC   = 5;
  localparam int SETTLE = SYNC + 4;

  logic       clk, rstN, busReqN, nmiN, cycleEnd, instrEnd, haltInstr, intEnable;
  logic [2:0] intN, intMask;
  logic       addrOe, dataOe, ctrlOe, busAckN, m1N, iorqN, haltN, ackActive;
  logic [1:0] ackKind;

  int checks = 0;
  int errors = 0;

  intBusArbiter #(.SYNC_STAGES(SYNC), .ACK_CYCLES(ACKC)) u0 (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .nmiN(nmiN), .intN(intN),
    .cycleEnd(cycleEnd), .instrEnd(instrEnd), .haltInstr(haltInstr),
    .intEnable(intEnable), .intMask(intMask), .addrOe(addrOe), .dataOe(dataOe),
    .ctrlOe(ctrlOe), .busAckN(busAckN), .m1N(m1N), .iorqN(iorqN), .haltN(haltN),
    .ackActive(ackActive), .ackKind(ackKind)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseInstr(input logic h);
    @(negedge clk); instrEnd = 1'b1; haltInstr = h;
    @(negedge clk); instrEnd = 1'b0; haltInstr = 1'b0;
  endtask

  task automatic pulseCycle();
    @(negedge clk); cycleEnd = 1'b1;
    @(negedge clk); cycleEnd = 1'b0;
  endtask

  // outc: 0 nothing, 1 bus grant, 2+kind acknowledge
  task automatic observe(output int outc, output int ackLen, output int strobeBad);
    outc = 0; ackLen = 0; strobeBad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!busAckN && outc == 0) outc = 1;
      if (ackActive) begin
        if (outc == 0) outc = 2 + int'(ackKind);
        ackLen++;
        if ((m1N == 1'b0) != (ackKind == 2'd1) || (iorqN == 1'b0) != (ackKind == 2'd1))
          strobeBad++;
      end
    end
  endtask

  task automatic idleInputs();
    busReqN = 1'b1; nmiN = 1'b1; intN = 3'b111;
  endtask

  task automatic drain();
    idleInputs();
    tick(SETTLE);
    for (int k = 0; k < 2; k++) begin
      pulseInstr(1'b0);
      tick(ACKC + 4);
    end
  endtask

  function automatic int expOut(input logic b, input logic n, input logic [2:0] irq,
                                input logic ie, input logic [2:0] mask);
    logic [2:0] ok;
    ok = irq & mask & {3{ie}};
    if (b) return 1;
    if (n) return 2;
    if (ok[0]) return 3;
    if (ok[1]) return 4;
    if (ok[2]) return 5;
    return 0;
  endfunction

  function automatic string reqTag(input int e);
    case (e)
      1: return "R1";
      2: return "R9";
      3: return "R3";
      4, 5: return "R4";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int outc, alen, sbad, oeIdx, ackIdx, e;
    logic b, n, ie;
    logic [2:0] irq, mask;

    rstN = 1'b0; cycleEnd = 1'b0; instrEnd = 1'b0; haltInstr = 1'b0;
    intEnable = 1'b0; intMask = 3'b000;
    idleInputs();
    tick(3);
    chk("R8 addrOe", int'(addrOe), 0);
    chk("R8 dataOe", int'(dataOe), 0);
    chk("R8 ctrlOe", int'(ctrlOe), 0);
    chk("R8 busAckN", int'(busAckN), 1);
    chk("R8 haltN", int'(haltN), 1);
    chk("R8 ackActive", int'(ackActive), 0);
    chk("R8 m1N/iorqN", int'(m1N & iorqN), 1);
    @(negedge clk); rstN = 1'b1;
    tick(3);
    chk("R8 enables after reset", int'(addrOe & dataOe & ctrlOe), 1);

    // R12 then R3/R5: interrupt 0 ignored at a cycle end, taken at an instruction end
    intEnable = 1'b1; intMask = 3'b111; intN = 3'b110;
    tick(SETTLE);
    pulseCycle();
    observe(outc, alen, sbad);
    chk("R12 no ack at cycle end", outc, 0);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R3 int0 accepted", outc, 3);
    chk("R5 int0 ack length", alen, ACKC);
    chk("R5 m1N/iorqN low", sbad, 0);
    intN = 3'b111;
    tick(SETTLE);

    // R1/R2: bus taken mid-instruction, drivers off before acknowledge
    busReqN = 1'b0;
    tick(SETTLE);
    pulseCycle();
    oeIdx = -1; ackIdx = -1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!addrOe && oeIdx < 0) oeIdx = i;
      if (!busAckN && ackIdx < 0) ackIdx = i;
    end
    chk("R1 grant at cycle end", int'(ackIdx >= 0), 1);
    chk("R2 release before ack", int'(oeIdx >= 0 && ackIdx > oeIdx), 1);
    busReqN = 1'b1;
    tick(SETTLE + 2);
    chk("R2 busAckN after release", int'(busAckN), 1);
    chk("R2 enables after release", int'(addrOe & dataOe & ctrlOe), 1);

    // R1: bus over NMI and all interrupts
    busReqN = 1'b0; nmiN = 1'b0; intN = 3'b000;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R1 bus wins", outc, 1);
    drain();

    // R9/R6: NMI edge, no second ack while held low
    nmiN = 1'b0;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R9 nmi accepted", outc, 2);
    chk("R6 nmi strobes high", sbad, 0);
    chk("R6 nmi ack length", alen, ACKC);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R9 held nmi not repeated", outc, 0);
    nmiN = 1'b1;
    tick(SETTLE);

    // R4 priority and R3 among maskables
    intN = 3'b001;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R4 int1 over int2", outc, 4);
    chk("R6 int1 strobes high", sbad, 0);
    intN = 3'b011;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R4 int2 alone", outc, 5);
    intN = 3'b010;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R3 int0 over int2", outc, 3);

    // R10 gating
    intMask = 3'b110; intN = 3'b110;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R10 masked int0", outc, 0);
    intMask = 3'b111; intEnable = 1'b0; intN = 3'b000;
    tick(SETTLE);
    pulseInstr(1'b0);
    observe(outc, alen, sbad);
    chk("R10 global disable", outc, 0);
    intEnable = 1'b1; intN = 3'b111;
    tick(SETTLE);

    // R7: halt, disabled request does not wake, enabled one does
    pulseInstr(1'b1);
    tick(3);
    chk("R7 haltN low", int'(haltN), 0);
    intMask = 3'b000; intN = 3'b110;
    tick(SETTLE + 10);
    chk("R10 disabled int keeps halt", int'(haltN), 0);
    intMask = 3'b001;
    observe(outc, alen, sbad);
    chk("R7 wake by int0", outc, 3);
    chk("R7 haltN high after wake", int'(haltN), 1);
    intN = 3'b111; intMask = 3'b111;
    tick(SETTLE);

    // R11: grant during halt
    pulseInstr(1'b1);
    tick(3);
    busReqN = 1'b0;
    tick(SETTLE + 3);
    chk("R11 busAckN during halt", int'(busAckN), 0);
    chk("R11 haltN during grant", int'(haltN), 0);
    busReqN = 1'b1;
    tick(SETTLE + 3);
    chk("R11 busAckN released", int'(busAckN), 1);
    chk("R11 back in halt", int'(haltN), 0);
    nmiN = 1'b0;
    observe(outc, alen, sbad);
    chk("R7 wake by nmi", outc, 2);
    chk("R7 haltN high after nmi", int'(haltN), 1);
    nmiN = 1'b1;
    drain();

    // Random mixes
    void'($urandom(32'd7031));
    for (int t = 0; t < 40; t++) begin
      b    = ($urandom % 4) == 0;
      n    = ($urandom % 3) == 0;
      irq  = 3'($urandom % 8);
      ie   = ($urandom % 4) != 0;
      mask = 3'($urandom % 8);
      busReqN = ~b; nmiN = ~n; intN = ~irq; intEnable = ie; intMask = mask;
      tick(SETTLE);
      pulseInstr(1'b0);
      observe(outc, alen, sbad);
      e = expOut(b, n, irq, ie, mask);
      chk(reqTag(e), outc, e);
      if (e >= 2) begin
        chk("R5 random ack length", alen, ACKC);
        chk("R6 random strobes", sbad, 0);
      end
      if (e == 1) begin
        busReqN = 1'b1;
        tick(SETTLE + 2);
        chk("R2 random release", int'(busAckN & addrOe), 1);
      end
      intEnable = 1'b1; intMask = 3'b111;
      drain();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule